// File: doc/BRIEF.md
# System Clock Pacer

This block paces a processor core by producing a one-cycle clock-enable. Two oscillators are modelled as tick inputs: `ring_tick` marks one cycle of a slow internal ring oscillator and `xtal_tick` marks one cycle of the fast external oscillator. The block runs the core either at the ring rate or at the fast rate divided by 1, 2, 4, 8 or 256. The divide-by-256 setting is a power-save mode. A switchback event can leave power-save mode automatically.

The block also sequences start-up and stop-mode exit.

- **Start-up:** after power-up it holds the core in reset for a fixed number of ring cycles. It then runs from the ring oscillator while it counts external-oscillator cycles, and only then hands the core over to the fast source.
- **Stop:** a stop request halts all enables. A wake event restarts the core after a fixed ring-cycle delay. The core then runs either from the previously selected divided source or, if the ring-hold bit is set, from the ring oscillator indefinitely.

A 6-bit control word is written through `cfg_wdata` with `cfg_we`. Bit fields: [1:0] divide select, [2] power-save, [3] switchback enable, [4] stop, [5] ring-hold. `cfg_rdata` returns these six bits, plus bit 6, which is high while the ring oscillator is the timing source.

Top module: `sysclk_pacer`

## Requirements
- R1: Reset and start-up.
  - After reset, `cfg_rdata` reads 0x40 and `sys_ready` and `clk_en` are low.
  - They stay low until `RING_HOLD` (10) `ring_tick` pulses have arrived. On the next cycle `sys_ready` rises and stays high.
  - From then on `clk_en` follows `ring_tick` and `ring_active` is high.
- R2: While running from the ring, `xtal_tick` produces no enable. Once `XTAL_WAIT` `xtal_tick` pulses have been counted with ring-hold at 0, the block switches to the fast source. `ring_active` then falls and `clk_en` is derived from `xtal_tick`.
- R3: The divide code is {power-save, divide select}. With this code, `clk_en` pulses on:
  - 000: every `xtal_tick`;
  - 001: every 2nd `xtal_tick`;
  - 010: every 4th `xtal_tick`;
  - 011: every 8th `xtal_tick`;
  - 1xx: every 256th `xtal_tick`.
- R4: A write leaves the divide-select field (bits [1:0]) unchanged while power-save (bit 2) is 1.
- R5: Power-save is set only by a write whose resulting divide select is 00. A write of bit 2 with a non-zero divide select leaves power-save at 0. Whenever power-save is 1, divide select reads 00.
- R6: Clearing power-save by a write leaves divide select at 00, so the ratio returns to divide-by-1.
- R7: Switchback.
  - A `sb_event` pulse while switchback enable (bit 3) and power-save are both 1 clears power-save on the next edge and returns to divide-by-1.
  - With switchback enable at 0, `sb_event` is ignored.
- R8: A new divide code takes effect only when the period in progress completes. `active_code` changes at the edge after a `clk_en` pulse, and the old period is never shortened.
- R9: Stop.
  - Writing 1 to bit 4 sets the stop flag. From the second cycle after the write, `clk_en` stays low and `ring_active` is low.
  - Writing 0 to bit 4 does not clear the stop flag.
- R10: Wake without ring-hold.
  - A `wake_event` pulse while stopped clears the stop flag. `clk_en` then stays low for `RING_HOLD` `ring_tick` pulses, with `ring_active` high.
  - With ring-hold at 0, the block then resumes the previously selected divided source.
- R11: Wake with ring-hold.
  - With ring-hold (bit 5) at 1 at wake, the block runs from the ring indefinitely: `clk_en` follows `ring_tick` and `ring_active` stays high.
  - Clearing ring-hold after `XTAL_WAIT` `xtal_tick` pulses returns the block to the fast source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| ring_tick | input | 1 | One-cycle pulse per ring-oscillator cycle |
| xtal_tick | input | 1 | One-cycle pulse per external-oscillator cycle |
| cfg_we | input | 1 | Control-word write strobe |
| cfg_wdata | input | 6 | Control word to write |
| sb_event | input | 1 | Switchback trigger pulse |
| wake_event | input | 1 | Stop-exit trigger pulse |
| clk_en | output | 1 | Core clock-enable pulse |
| cfg_rdata | output | 7 | Control word readback plus ring status in bit 6 |
| sys_ready | output | 1 | High once the start-up reset hold is released |
| ring_active | output | 1 | High while the ring oscillator is the timing source |
| active_code | output | 3 | Divide code currently applied by the divider |

## Verification
The checks assume that reset is held for at least two cycles from time zero. They also assume that the tick, switchback and wake inputs are single-cycle pulses that change only between clock edges. The bench drives every input just after a rising edge. Each tick lasts exactly one cycle, and reset is held for four cycles. Write and event strobes are always dropped on the following cycle, and a stop request is never issued while the block is still in the wake delay.

// File: rtl/pacer_pkg.sv
package pacer_pkg;

    localparam int CTRL_W    = 6;
    localparam int RDATA_W   = CTRL_W + 1;
    localparam int CODE_W    = 3;
    localparam int DIV_CNT_W = 8;

    typedef enum logic [2:0] {
        SRC_POR  = 3'd0,
        SRC_RING = 3'd1,
        SRC_XTAL = 3'd2,
        SRC_STOP = 3'd3,
        SRC_WAKE = 3'd4
    } src_state_e;

    // Field order matches the write/read bit layout [5:0].
    typedef struct packed {
        logic       ring_hold;
        logic       stop;
        logic       sb_en;
        logic       pwr_save;
        logic [1:0] div_sel;
    } ctrl_t;

    // Last count value of one divided period for a divide code.
    function automatic logic [DIV_CNT_W-1:0] period_last(input logic [CODE_W-1:0] code);
        logic [DIV_CNT_W-1:0] last;
        case (code)
            3'b000:  last = DIV_CNT_W'(0);
            3'b001:  last = DIV_CNT_W'(1);
            3'b010:  last = DIV_CNT_W'(3);
            3'b011:  last = DIV_CNT_W'(7);
            default: last = DIV_CNT_W'(255);
        endcase
        return last;
    endfunction

endpackage

// File: rtl/pacer_ctrl_reg.sv
module pacer_ctrl_reg
    import pacer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              sb_event,
    input  logic              wake_event,
    output ctrl_t             ctrl
);

    ctrl_t ctrl_q;
    ctrl_t ctrl_d;
    ctrl_t wr;
    logic  sb_hit;

    assign wr     = ctrl_t'(wdata);
    assign sb_hit = sb_event && ctrl_q.sb_en && ctrl_q.pwr_save;

    always_comb begin
        ctrl_d = ctrl_q;
        if (we) begin
            // divide select is locked while power-save is on
            if (!ctrl_q.pwr_save) begin
                ctrl_d.div_sel = wr.div_sel;
            end
            ctrl_d.sb_en     = wr.sb_en;
            ctrl_d.ring_hold = wr.ring_hold;
            if (wr.stop) begin
                ctrl_d.stop = 1'b1;
            end
            if (wr.pwr_save) begin
                if (ctrl_d.div_sel == 2'b00) begin
                    ctrl_d.pwr_save = 1'b1;
                end
            end else begin
                ctrl_d.pwr_save = 1'b0;
            end
        end
        if (sb_hit) begin
            ctrl_d.pwr_save = 1'b0;
        end
        // any exit from power-save lands on divide-by-1
        if (ctrl_q.pwr_save && !ctrl_d.pwr_save) begin
            ctrl_d.div_sel = 2'b00;
        end
        if (wake_event && ctrl_q.stop) begin
            ctrl_d.stop = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ctrl = ctrl_q;

endmodule

// File: rtl/pacer_seq.sv
module pacer_seq
    import pacer_pkg::*;
#(
    parameter int RING_HOLD = 10,
    parameter int XTAL_WAIT = 8192
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ring_tick,
    input  logic       xtal_tick,
    input  logic       stop_flag,
    input  logic       wake_event,
    input  logic       ring_hold,
    output src_state_e state
);

    localparam int CNT_MAX = (RING_HOLD > XTAL_WAIT) ? RING_HOLD : XTAL_WAIT;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] RING_LAST = CNT_W'(RING_HOLD - 1);
    localparam logic [CNT_W-1:0] XTAL_DONE = CNT_W'(XTAL_WAIT);

    src_state_e       st_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SRC_POR;
            cnt_q <= '0;
        end else begin
            case (st_q)
                SRC_POR: begin
                    if (ring_tick) begin
                        if (cnt_q == RING_LAST) begin
                            st_q  <= stop_flag ? SRC_STOP : SRC_RING;
                            cnt_q <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                SRC_RING: begin
                    if (stop_flag) begin
                        st_q  <= SRC_STOP;
                        cnt_q <= '0;
                    end else if (cnt_q == XTAL_DONE && !ring_hold) begin
                        st_q  <= SRC_XTAL;
                        cnt_q <= '0;
                    end else if (xtal_tick && cnt_q != XTAL_DONE) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SRC_XTAL: begin
                    if (stop_flag) begin
                        st_q <= SRC_STOP;
                    end
                end
                SRC_STOP: begin
                    if (wake_event) begin
                        st_q  <= SRC_WAKE;
                        cnt_q <= '0;
                    end
                end
                SRC_WAKE: begin
                    if (ring_tick) begin
                        if (cnt_q == RING_LAST) begin
                            cnt_q <= '0;
                            if (stop_flag) begin
                                st_q <= SRC_STOP;
                            end else if (ring_hold) begin
                                st_q <= SRC_RING;
                            end else begin
                                st_q <= SRC_XTAL;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: begin
                    st_q  <= SRC_POR;
                    cnt_q <= '0;
                end
            endcase
        end
    end

    assign state = st_q;

endmodule

// File: rtl/pacer_divider.sv
module pacer_divider
    import pacer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              xtal_tick,
    input  logic [CODE_W-1:0] target_code,
    output logic              pulse,
    output logic [CODE_W-1:0] active_code
);

    logic [DIV_CNT_W-1:0] cnt_q;
    logic [CODE_W-1:0]    code_q;
    logic                 at_end;

    assign at_end = (cnt_q == period_last(code_q));
    assign pulse  = run && xtal_tick && at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            code_q <= '0;
        end else if (!run) begin
            cnt_q  <= '0;
            code_q <= target_code;
        end else if (xtal_tick) begin
            if (at_end) begin
                cnt_q  <= '0;
                code_q <= target_code;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign active_code = code_q;

endmodule

// File: rtl/sysclk_pacer.sv
module sysclk_pacer
    import pacer_pkg::*;
#(
    parameter int RING_HOLD = 10,
    parameter int XTAL_WAIT = 8192
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ring_tick,
    input  logic               xtal_tick,
    input  logic               cfg_we,
    input  logic [CTRL_W-1:0]  cfg_wdata,
    input  logic               sb_event,
    input  logic               wake_event,
    output logic               clk_en,
    output logic [RDATA_W-1:0] cfg_rdata,
    output logic               sys_ready,
    output logic               ring_active,
    output logic [CODE_W-1:0]  active_code
);

    ctrl_t             ctrl;
    src_state_e        seq_state;
    logic              div_pulse;
    logic              xtal_run;
    logic [CODE_W-1:0] target_code;

    pacer_ctrl_reg u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .we         (cfg_we),
        .wdata      (cfg_wdata),
        .sb_event   (sb_event),
        .wake_event (wake_event),
        .ctrl       (ctrl)
    );

    pacer_seq #(
        .RING_HOLD (RING_HOLD),
        .XTAL_WAIT (XTAL_WAIT)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .ring_tick  (ring_tick),
        .xtal_tick  (xtal_tick),
        .stop_flag  (ctrl.stop),
        .wake_event (wake_event),
        .ring_hold  (ctrl.ring_hold),
        .state      (seq_state)
    );

    assign target_code = {ctrl.pwr_save, ctrl.div_sel};
    assign xtal_run    = (seq_state == SRC_XTAL);

    pacer_divider u_div (
        .clk         (clk),
        .rst         (rst),
        .run         (xtal_run),
        .xtal_tick   (xtal_tick),
        .target_code (target_code),
        .pulse       (div_pulse),
        .active_code (active_code)
    );

    assign ring_active = (seq_state == SRC_POR) || (seq_state == SRC_RING) ||
                         (seq_state == SRC_WAKE);
    assign sys_ready   = (seq_state != SRC_POR);
    assign clk_en      = ((seq_state == SRC_RING) && ring_tick) || div_pulse;
    assign cfg_rdata   = {ring_active, ctrl};

endmodule

// File: rtl/pacer_checker.sv
module pacer_checker (
    input logic       clk,
    input logic       rst,
    input logic       clk_en,
    input logic       sys_ready,
    input logic       sb_event,
    input logic [4:0] ctl,
    input logic [2:0] active_code
);

    assert_no_early_enable_R1: assert property (@(posedge clk) disable iff (rst)
        !sys_ready |-> !clk_en);

    assert_ready_holds_R1: assert property (@(posedge clk) disable iff (rst)
        $past(sys_ready) |-> sys_ready);

    assert_save_div_zero_R5: assert property (@(posedge clk) disable iff (rst)
        ctl[2] |-> (ctl[1:0] == 2'b00));

    assert_switchback_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (sb_event && ctl[3] && ctl[2]) |=> !ctl[2]);

    assert_stop_gates_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(ctl[4]) && ctl[4]) |-> !clk_en);

    assert_code_form_R3: assert property (@(posedge clk) disable iff (rst)
        active_code[2] |-> (active_code[1:0] == 2'b00));

endmodule

bind sysclk_pacer pacer_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .clk_en      (clk_en),
    .sys_ready   (sys_ready),
    .sb_event    (sb_event),
    .ctl         (cfg_rdata[4:0]),
    .active_code (active_code)
);

// File: tb/sim_sysclk_pacer.sv
module sim_sysclk_pacer;

    localparam int RH = 10;
    localparam int XW = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ring_tick = 1'b0;
    logic       xtal_tick = 1'b0;
    logic       cfg_we = 1'b0;
    logic [5:0] cfg_wdata = '0;
    logic       sb_event = 1'b0;
    logic       wake_event = 1'b0;
    logic       clk_en;
    logic [6:0] cfg_rdata;
    logic       sys_ready;
    logic       ring_active;
    logic [2:0] active_code;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;

    sysclk_pacer #(.RING_HOLD(RH), .XTAL_WAIT(XW)) u0 (
        .clk(clk), .rst(rst), .ring_tick(ring_tick), .xtal_tick(xtal_tick),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .sb_event(sb_event),
        .wake_event(wake_event), .clk_en(clk_en), .cfg_rdata(cfg_rdata),
        .sys_ready(sys_ready), .ring_active(ring_active), .active_code(active_code)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input logic r, input logic x, input logic we = 1'b0,
                       input logic [5:0] wd = '0, input logic sb = 1'b0,
                       input logic wk = 1'b0);
        @(posedge clk);
        #2;
        ring_tick  = r;
        xtal_tick  = x;
        cfg_we     = we;
        cfg_wdata  = wd;
        sb_event   = sb;
        wake_event = wk;
        @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] d);
        cyc(1'b0, 1'b0, 1'b1, d);
        cyc(1'b0, 1'b0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0);
    endtask

    task automatic count_xtal(input int n, output int p);
        p = 0;
        for (int i = 0; i < n; i++) begin
            cyc(1'b0, 1'b1);
            if (clk_en) p++;
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic t_reset_startup();
        int p;
        check("R1", "rdata after reset", cfg_rdata, 32'h40);
        check("R1", "sys_ready after reset", sys_ready, 0);
        p = 0;
        for (int i = 0; i < RH - 1; i++) begin
            cyc(1'b1, 1'b0);
            if (clk_en || sys_ready) p++;
            cyc(1'b0, 1'b0);
        end
        check("R1", "enable or ready during hold", p, 0);
        cyc(1'b1, 1'b0);
        check("R1", "clk_en on last hold tick", clk_en, 0);
        cyc(1'b0, 1'b0);
        check("R1", "sys_ready after hold", sys_ready, 1);
        check("R1", "ring_active after hold", ring_active, 1);
        cyc(1'b1, 1'b0);
        check("R1", "clk_en follows ring", clk_en, 1);
        cyc(1'b0, 1'b0);
        check("R1", "clk_en low without ring tick", clk_en, 0);
    endtask

    task automatic t_warmup();
        int p;
        count_xtal(XW - 1, p);
        check("R2", "xtal pulses while on ring", p, 0);
        cyc(1'b0, 1'b0);
        check("R2", "still on ring before last tick", ring_active, 1);
        cyc(1'b0, 1'b1);
        idle(2);
        check("R2", "ring released after wait", ring_active, 0);
        cyc(1'b0, 1'b1);
        check("R2", "clk_en from xtal", clk_en, 1);
    endtask

    task automatic t_write_rules();
        wr(6'h01);
        check("R4", "div write when not saving", cfg_rdata, 32'h01);
        wr(6'h05);
        check("R5", "save refused with nonzero div", cfg_rdata, 32'h01);
        wr(6'h04);
        check("R5", "save entered with div 00", cfg_rdata, 32'h04);
        wr(6'h06);
        check("R4", "div locked in save", cfg_rdata, 32'h04);
        wr(6'h00);
        check("R6", "save cleared div 00", cfg_rdata, 32'h00);
    endtask

    task automatic t_ratios();
        int p;
        for (int d = 0; d < 4; d++) begin
            wr(6'(d));
            count_xtal(256, p);
            count_xtal(512, p);
            check("R3", $sformatf("pulses in 512 ticks div %0d", d), p, 512 >> d);
        end
        wr(6'h04);
        count_xtal(256, p);
        count_xtal(512, p);
        check("R3", "pulses in 512 ticks power-save", p, 2);
        wr(6'h00);
        count_xtal(256, p);
        count_xtal(16, p);
        check("R6", "ratio after leaving save", p, 16);
    endtask

    task automatic t_switchback();
        int p;
        wr(6'h0C);
        check("R7", "save with switchback enabled", cfg_rdata, 32'h0C);
        cyc(1'b0, 1'b0, 1'b0, '0, 1'b1);
        cyc(1'b0, 1'b0);
        check("R7", "switchback clears save", cfg_rdata, 32'h08);
        count_xtal(256, p);
        count_xtal(16, p);
        check("R7", "divide-by-1 after switchback", p, 16);
        wr(6'h04);
        cyc(1'b0, 1'b0, 1'b0, '0, 1'b1);
        cyc(1'b0, 1'b0);
        check("R7", "switchback ignored when disabled", cfg_rdata, 32'h04);
        wr(6'h00);
        count_xtal(256, p);
    endtask

    task automatic t_boundary();
        int p;
        wr(6'h03);
        count_xtal(256, p);
        for (int i = 0; i < 8; i++) begin
            cyc(1'b0, 1'b1);
            if (clk_en) break;
        end
        count_xtal(3, p);
        wr(6'h00);
        count_xtal(4, p);
        check("R8", "old period not shortened", p, 0);
        check("R8", "code held mid-period", active_code, 3);
        cyc(1'b0, 1'b1);
        check("R8", "pulse at old period end", clk_en, 1);
        cyc(1'b0, 1'b1);
        check("R8", "new ratio after boundary", clk_en, 1);
        check("R8", "code updated at boundary", active_code, 0);
    endtask

    task automatic t_stop_wake();
        int p;
        wr(6'h01);
        count_xtal(16, p);
        wr(6'h11);
        check("R9", "stop flag set", cfg_rdata, 32'h11);
        p = 0;
        for (int i = 0; i < 20; i++) begin
            cyc(1'b1, 1'b1);
            if (clk_en || ring_active) p++;
        end
        check("R9", "no enable while stopped", p, 0);
        wr(6'h01);
        check("R9", "zero write keeps stop", cfg_rdata, 32'h11);
        cyc(1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b1);
        p = 0;
        for (int i = 0; i < RH - 1; i++) begin
            cyc(1'b1, 1'b1);
            if (clk_en || !ring_active) p++;
        end
        check("R10", "quiet ring delay after wake", p, 0);
        check("R10", "stop cleared by wake", cfg_rdata[4], 0);
        cyc(1'b1, 1'b0);
        check("R10", "no enable on last delay tick", clk_en, 0);
        cyc(1'b0, 1'b0);
        check("R10", "back on fast source", ring_active, 0);
        count_xtal(16, p);
        check("R10", "divide-by-2 resumed", p, 8);
    endtask

    task automatic t_ring_hold();
        int p;
        wr(6'h21);
        wr(6'h31);
        idle(2);
        cyc(1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b1);
        for (int i = 0; i < RH; i++) cyc(1'b1, 1'b0);
        cyc(1'b0, 1'b0);
        check("R11", "ring kept after wake", ring_active, 1);
        cyc(1'b1, 1'b0);
        check("R11", "enable follows ring", clk_en, 1);
        count_xtal(XW + 5, p);
        check("R11", "no xtal enable in ring hold", p, 0);
        check("R11", "still on ring after wait", ring_active, 1);
        wr(6'h01);
        idle(2);
        check("R11", "fast source after hold cleared", ring_active, 0);
        count_xtal(16, p);
        check("R11", "divide-by-2 after hold cleared", p, 8);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #2;
        rst = 1'b0;
        @(negedge clk);
        t_reset_startup();
        t_warmup();
        t_write_rules();
        t_ratios();
        t_switchback();
        t_boundary();
        t_stop_wake();
        t_ring_hold();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule